// File: doc/BRIEF.md
# Ramp Sequence Integrity Checker

This block watches a stream of captured samples that is expected to be a counting ramp, one step per valid sample. It shows whether the capture path delivered every sample exactly once. Each pair of consecutive valid samples is sorted into one of three classes. A step of one is good. An equal pair is a duplicate, which is what a double-rate demultiplexer wrongly applied to a single-rate source leaves behind. Any other step is a jump, which is what a dropped or corrupted sample leaves behind.

A start pulse opens a run and clears the tallies. The run closes after `RUN_LEN` valid samples, or earlier on an external stop pulse. When it closes, the checker pulses `done` and latches a pass/fail verdict. The verdict allows a small shortfall of good steps for start-up effects, but it never excuses a duplicate or a jump.

Top module: `ramp_audit`

## Requirements
- R1: A start pulse clears `good_cnt`, `dup_cnt`, `jump_cnt` and `pass` to zero; the cleared values are visible after the edge that samples `start`. A sample offered in the same cycle as `start` is ignored.
- R2: The first valid sample after start sets the reference only and changes no count.
- R3: A valid sample equal to the previous valid sample plus one, taken modulo 2^`DW`, increments `good_cnt`. This includes the step from all ones to zero.
- R4: A valid sample equal to the previous valid sample increments `dup_cnt`.
- R5: Any other step between consecutive valid samples, forward or backward, increments `jump_cnt`.
- R6: The block ignores a sample in two cases: when `smp_vld` is low, and when no run is open (before the first start or after a run has closed).
- R7: Once `RUN_LEN` valid samples have been taken, the run closes. `done` is high for exactly one cycle, in the cycle after the edge that took the last sample.
- R8: A `stop` pulse during an open run closes it, with the same `done` timing. A valid sample offered in the same cycle as `stop` is still classified and counted before the verdict.
- R9: `pass` is set when the run closes, only if good steps + `SLACK` ≥ samples taken and both `dup_cnt` and `jump_cnt` are zero. It then holds its value until the next start.
- R10: A `stop` pulse while no run is open produces no `done` and leaves `pass` and all counts unchanged.
- R11: Reset clears the counts, `pass` and `done`, and closes any open run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a new run and clears tallies |
| stop | input | 1 | Closes the open run early |
| smp_vld | input | 1 | Sample qualifier |
| smp_data | input | DW | Captured sample |
| done | output | 1 | One-cycle pulse when a run closes |
| pass | output | 1 | Latched verdict of the last closed run |
| good_cnt | output | $clog2(RUN_LEN+1) | Count of +1 steps |
| dup_cnt | output | $clog2(RUN_LEN+1) | Count of repeated samples |
| jump_cnt | output | $clog2(RUN_LEN+1) | Count of other steps |

## Verification
Two functions can fall in the same cycle: the classification of a final sample, and the closing of the run by `stop`. The bench presents `stop` together with a valid sample twice. In one case the sample is a clean step, and `pass` must be high with the good count including it. In the other case the sample is a duplicate, and `pass` must be low with `dup_cnt` at one. This shows that the verdict is formed from the counts as updated by that last sample. The natural end of a run also coincides with the 64th sample's classification. That case is judged by a full wrapping ramp that must close with 63 good steps and a pass.

// File: rtl/ramp_audit.sv
module ramp_audit #(
  parameter int DW      = 16,
  parameter int RUN_LEN = 64,
  parameter int SLACK   = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         stop,
  input  logic                         smp_vld,
  input  logic [DW-1:0]                smp_data,
  output logic                         done,
  output logic                         pass,
  output logic [$clog2(RUN_LEN+1)-1:0] good_cnt,
  output logic [$clog2(RUN_LEN+1)-1:0] dup_cnt,
  output logic [$clog2(RUN_LEN+1)-1:0] jump_cnt
);
  localparam int CW = $clog2(RUN_LEN+1);

  logic          active, have_ref;
  logic [DW-1:0] ref_q;
  logic [CW-1:0] smp_q;

  wire          take    = active && smp_vld && !start;
  wire [DW-1:0] delta   = smp_data - ref_q;
  wire          cmp     = take && have_ref;
  wire          is_good = cmp && (delta == DW'(1));
  wire          is_dup  = cmp && (delta == '0);
  wire          is_jump = cmp && !is_good && !is_dup;

  wire [CW-1:0] good_n = good_cnt + CW'(is_good);
  wire [CW-1:0] dup_n  = dup_cnt  + CW'(is_dup);
  wire [CW-1:0] jump_n = jump_cnt + CW'(is_jump);
  wire [CW-1:0] smp_n  = smp_q    + CW'(take);

  wire finish  = active && !start && (stop || (take && smp_n == CW'(RUN_LEN)));
  wire verdict = ({1'b0, good_n} + (CW+1)'(SLACK) >= {1'b0, smp_n}) &&
                 (dup_n == '0) && (jump_n == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      have_ref <= 1'b0;
      ref_q    <= '0;
      smp_q    <= '0;
      good_cnt <= '0;
      dup_cnt  <= '0;
      jump_cnt <= '0;
      done     <= 1'b0;
      pass     <= 1'b0;
    end else begin
      done <= finish;
      if (start) begin
        active   <= 1'b1;
        have_ref <= 1'b0;
        smp_q    <= '0;
        good_cnt <= '0;
        dup_cnt  <= '0;
        jump_cnt <= '0;
        pass     <= 1'b0;
      end else begin
        if (take) begin
          have_ref <= 1'b1;
          ref_q    <= smp_data;
        end
        smp_q    <= smp_n;
        good_cnt <= good_n;
        dup_cnt  <= dup_n;
        jump_cnt <= jump_n;
        if (finish) begin
          active <= 1'b0;
          pass   <= verdict;
        end
      end
    end
  end

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (good_cnt == '0 && dup_cnt == '0 && jump_cnt == '0 && !pass));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_dup_fails_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dup_cnt != '0) |-> !pass);

  assert_jump_fails_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && jump_cnt != '0) |-> !pass);

  assert_pass_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !finish) |=> $stable(pass));

  assert_idle_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> (!done && $stable(good_cnt) && $stable(dup_cnt) && $stable(jump_cnt)));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, good_cnt} + {1'b0, dup_cnt} + {1'b0, jump_cnt} < (CW+1)'(RUN_LEN)));
endmodule

// File: tb/test_ramp_audit.sv
module test_ramp_audit;
  localparam int DW = 16;
  localparam int CW = 7;

  logic clk = 0, rst_n = 0, start = 0, stop = 0, smp_vld = 0;
  logic [DW-1:0] smp_data = '0;
  logic done, pass;
  logic [CW-1:0] good_cnt, dup_cnt, jump_cnt;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ramp_audit i_ramp_audit (.clk, .rst_n, .start, .stop, .smp_vld, .smp_data,
    .done, .pass, .good_cnt, .dup_cnt, .jump_cnt);

  // row: vld, data, expected good, dup, jump after the sample is taken
  localparam int NV = 12;
  localparam logic [40:0] TBL [NV] = '{
    {1'b1, 16'h0010, 8'd0, 8'd0, 8'd0},  // R2 reference only
    {1'b1, 16'h0011, 8'd1, 8'd0, 8'd0},  // R3
    {1'b0, 16'h0099, 8'd1, 8'd0, 8'd0},  // R6 invalid ignored
    {1'b1, 16'h0012, 8'd2, 8'd0, 8'd0},  // R3 across gap
    {1'b1, 16'h0012, 8'd2, 8'd1, 8'd0},  // R4
    {1'b1, 16'h0013, 8'd3, 8'd1, 8'd0},
    {1'b1, 16'h0015, 8'd3, 8'd1, 8'd1},  // R5 forward
    {1'b1, 16'hFFFF, 8'd3, 8'd1, 8'd2},  // R5
    {1'b1, 16'h0000, 8'd4, 8'd1, 8'd2},  // R3 wrap
    {1'b1, 16'h0001, 8'd5, 8'd1, 8'd2},
    {1'b1, 16'h0000, 8'd5, 8'd1, 8'd3},  // R5 backward
    {1'b1, 16'h0001, 8'd6, 8'd1, 8'd3}
  };

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_start();
    start = 1; tick(); start = 0;
  endtask

  task automatic chk_cnt(string req, int g, int d, int j);
    chk({req, " good"}, good_cnt, g);
    chk({req, " dup"}, dup_cnt, d);
    chk({req, " jump"}, jump_cnt, j);
  endtask

  initial begin
    #3000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R11 reset done", done, 0);
    chk("R11 reset pass", pass, 0);
    chk_cnt("R11 reset", 0, 0, 0);
    rst_n = 1; tick();

    // R6: samples before any start are ignored
    smp_vld = 1; smp_data = 5; tick(); smp_data = 6; tick(); smp_vld = 0;
    chk_cnt("R6 idle", 0, 0, 0);

    // vector walk
    do_start();
    for (int i = 0; i < NV; i++) begin
      smp_vld = TBL[i][40]; smp_data = TBL[i][39:24];
      tick();
      chk_cnt($sformatf("R3/R4/R5 row%0d", i), TBL[i][23:16], TBL[i][15:8], TBL[i][7:0]);
    end
    smp_vld = 0; stop = 1; tick(); stop = 0;
    chk("R8 stop done", done, 1);
    chk("R9 fail with dup/jump", pass, 0);
    tick();
    chk("R7 done one cycle", done, 0);

    // R1: start clears, sample in start cycle ignored
    smp_vld = 1; smp_data = 16'h0100; start = 1; tick(); start = 0;
    chk_cnt("R1 clear", 0, 0, 0);
    chk("R1 pass cleared", pass, 0);
    smp_data = 16'h0102; tick(); smp_vld = 0;
    chk_cnt("R1 start-cycle sample ignored", 0, 0, 0);

    // R7: full ramp crossing wrap
    do_start();
    for (int k = 0; k < 64; k++) begin
      smp_vld = 1; smp_data = 16'hFFE0 + 16'(k);
      tick();
      if (k < 63) chk("R7 no early done", done, 0);
    end
    smp_vld = 0;
    chk("R7 done after last", done, 1);
    chk("R9 pass clean ramp", pass, 1);
    chk_cnt("R7 full", 63, 0, 0);
    smp_vld = 1; smp_data = 16'h0020; tick(); smp_vld = 0;
    chk("R7 single pulse", done, 0);
    chk_cnt("R6 after close", 63, 0, 0);

    // R10: stop while idle
    stop = 1; tick(); stop = 0; tick();
    chk("R10 idle stop no done", done, 0);
    chk("R10 pass held", pass, 1);
    chk_cnt("R10 counts held", 63, 0, 0);

    // R8: clean final sample together with stop
    do_start();
    smp_vld = 1;
    smp_data = 5; tick(); smp_data = 6; tick();
    smp_data = 7; stop = 1; tick(); stop = 0; smp_vld = 0;
    chk("R8 same-cycle done", done, 1);
    chk("R8 same-cycle pass", pass, 1);
    chk_cnt("R8 last counted", 2, 0, 0);

    // R8: duplicate final sample together with stop
    do_start();
    smp_vld = 1;
    smp_data = 9; tick(); smp_data = 10; tick();
    stop = 1; tick(); stop = 0; smp_vld = 0;
    chk("R8 dup with stop pass", pass, 0);
    chk_cnt("R8 dup with stop", 1, 1, 0);
    tick();
    chk("R9 fail held", pass, 0);

    // R11: reset mid-run
    do_start();
    smp_vld = 1; smp_data = 1; tick(); smp_data = 2; tick(); smp_vld = 0;
    rst_n = 0; #1;
    chk_cnt("R11 async reset", 0, 0, 0);
    tick(); rst_n = 1; tick();
    stop = 1; tick(); stop = 0;
    chk("R11 run closed by reset", done, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule